// File: doc/BRIEF.md
# Destructive-Read Word Memory with Regeneration Latch

This block is a small word store in which every read empties the word it touches. A read sends the word's set bits out and, at the same time, loads them into a regeneration latch. Data therefore lasts only if the latch writes it back. To write back, a row is opened, the latch is told to copy, and the row is then committed. A write works by capture. A write strobe opens one row and injects a bit pattern. Any further lanes injected while the row stays open pile up in a capture register. A commit strobe then ORs the captured pattern into the stored word and closes the row.

Three sources can inject bits into the eight data lanes: the write data, an all-ones inject, and a copy from the regeneration latch. When no row is open, these bits pass through the store untouched and appear on a pass-through output. The latch can also release its contents to downstream logic, which empties it. Every output is registered and appears one clock after the strobe that caused it. A synchronous active-high reset empties every word, the capture register and the latch.

Top module: `dr_word_mem`

## Requirements
- R1: Reset clears every word, the open-row state and the latch. In the first cycle after reset, rd_valid, fwd_valid and pass_valid are all 0, and every address then reads as 0x00.
- R2: The address drives a one-hot row decode. A commit changes only the word of the row that was opened, and all other words keep their values.
- R3: A read returns the stored word on rd_data and leaves that word at 0x00. A second read of the same address, with no commit in between, returns 0x00.
- R4: A write strobe opens the addressed row and captures wr_data. The stored word does not change until a commit strobe. The commit ORs the captured bits into the word and closes the row.
- R5: If a word is written and committed a second time with no read in between, the result is the OR of both patterns.
- R6: With no row open, lanes injected by inject_all or by a regenerator copy appear on pass_data with pass_valid = 1. No word changes.
- R7: inject_all drives 0xFF on all eight lanes. The ones land in the open row if there is one, and on pass_data if there is not.
- R8: A read loads the read word into the regeneration latch. The regen_cmd encoding is 0 = neutral, 1 = copy, 2 = release, and 3 = neutral. A copy injects the latch contents into the lanes without emptying the latch, so copying into an open row and then committing restores the word.
- R9: A release puts the latch contents on fwd_data with fwd_valid = 1 and empties the latch, so a second release forwards 0x00. If a read and a release fall in the same cycle, the old contents are forwarded and the latch takes the newly read word.
- R10: A copy issued while the latch is empty injects no ones.
- R11: When strobes coincide, a read wins over a commit, and a commit wins over a write. A losing strobe has no effect.
- R12: rd_valid, fwd_valid and pass_valid rise in the cycle after the strobe or command that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Word address for read and write |
| rd_stb | input | 1 | Destructive read of addr |
| wr_stb | input | 1 | Open row addr and inject wr_data |
| wr_data | input | 8 | Pattern injected by a write |
| commit_stb | input | 1 | OR the captured pattern into the open row and close it |
| inject_all | input | 1 | Inject ones on all lanes |
| regen_cmd | input | 2 | Latch command: 0 neutral, 1 copy, 2 release, 3 neutral |
| rd_valid | output | 1 | rd_data holds a read result |
| rd_data | output | 8 | Word read out |
| fwd_valid | output | 1 | fwd_data holds released latch contents |
| fwd_data | output | 8 | Released copy for downstream logic |
| pass_valid | output | 1 | Lanes passed through with no row open |
| pass_data | output | 8 | Passed-through lane pattern |

## Verification
The hardest case to reach is the full read-and-restore loop. The bench reads a word, which empties it and loads the latch. It then opens the same row with an all-zero write, issues a copy while the row is still open, commits, and finally reads the word again. Only that final read shows whether the copy reached the capture register rather than the pass-through path. The same stimulus is also run with an empty latch and with the row closed. Tie-break cycles, where strobes coincide, are built by driving two strobes in one step. The losing strobe is then shown to have had no effect by reading the word back or by injecting ones and watching where they go.

// File: rtl/dwm_pkg.sv
package dwm_pkg;
  typedef enum logic [1:0] {
    REGEN_HOLD    = 2'd0,
    REGEN_COPY    = 2'd1,
    REGEN_RELEASE = 2'd2,
    REGEN_IDLE    = 2'd3
  } regen_cmd_e;
endpackage

// File: rtl/dwm_row_decode.sv
module dwm_row_decode #(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   en,
  output logic [(1<<ADDR_W)-1:0] sel
);
  localparam int ROWS = 1 << ADDR_W;

  always_comb begin
    sel = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (en && (addr == ADDR_W'(r))) sel[r] = 1'b1;
    end
  end
endmodule

// File: rtl/dwm_word_array.sv
module dwm_word_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [(1<<ADDR_W)-1:0] rd_sel,
  input  logic [(1<<ADDR_W)-1:0] cm_sel,
  input  logic [DATA_W-1:0]      cm_bits,
  output logic [DATA_W-1:0]      sel_word
);
  localparam int ROWS = 1 << ADDR_W;

  logic [DATA_W-1:0] word_q [ROWS];

  // one storage row per address; read empties, commit ORs in
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst)            word_q[r] <= '0;
      else if (rd_sel[r]) word_q[r] <= '0;
      else if (cm_sel[r]) word_q[r] <= word_q[r] | cm_bits;
    end
  end

  always_comb begin
    sel_word = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (rd_sel[r]) sel_word = sel_word | word_q[r];
    end
  end
endmodule

// File: rtl/dwm_capture.sv
module dwm_capture #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_go,
  input  logic              cm_go,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] lanes,
  input  logic              lane_act,
  output logic              open_now,
  output logic [ADDR_W-1:0] row_now,
  output logic              commit_go,
  output logic [DATA_W-1:0] commit_bits,
  output logic              pass_go
);
  logic              open_q;
  logic [ADDR_W-1:0] row_q;
  logic [DATA_W-1:0] cap_q;

  assign open_now    = open_q | wr_go;
  assign row_now     = wr_go ? addr : row_q;
  assign commit_go   = cm_go & open_now;
  assign commit_bits = cap_q | lanes;
  assign pass_go     = ~open_now & lane_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      row_q  <= '0;
      cap_q  <= '0;
    end else if (commit_go) begin
      open_q <= 1'b0;
      cap_q  <= '0;
    end else if (open_now) begin
      open_q <= 1'b1;
      row_q  <= row_now;
      cap_q  <= cap_q | lanes;
    end
  end
endmodule

// File: rtl/dwm_regen.sv
module dwm_regen
  import dwm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_bits,
  input  regen_cmd_e        cmd,
  output logic              copy_act,
  output logic [DATA_W-1:0] copy_bits,
  output logic              rel_go,
  output logic [DATA_W-1:0] rel_bits
);
  logic [DATA_W-1:0] held_q;

  assign copy_act  = (cmd == REGEN_COPY);
  assign copy_bits = copy_act ? held_q : '0;
  assign rel_go    = (cmd == REGEN_RELEASE);
  assign rel_bits  = held_q;

  always_ff @(posedge clk) begin
    if (rst)         held_q <= '0;
    else if (load)   held_q <= load_bits;
    else if (rel_go) held_q <= '0;
  end
endmodule

// File: rtl/dr_word_mem.sv
module dr_word_mem
  import dwm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit_stb,
  input  logic              inject_all,
  input  logic [1:0]        regen_cmd,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              fwd_valid,
  output logic [DATA_W-1:0] fwd_data,
  output logic              pass_valid,
  output logic [DATA_W-1:0] pass_data
);
  localparam int ROWS = 1 << ADDR_W;

  regen_cmd_e        cmd;
  logic              rd_go, cm_go, wr_go;
  logic [DATA_W-1:0] lanes;
  logic              copy_act, rel_go, open_now, commit_go, pass_go;
  logic [DATA_W-1:0] copy_bits, rel_bits, commit_bits, sel_word;
  logic [ADDR_W-1:0] row_now;
  logic [ROWS-1:0]   rd_sel, cm_sel;

  assign cmd = regen_cmd_e'(regen_cmd);

  // tie-break: read over commit over write
  assign rd_go = rd_stb;
  assign cm_go = commit_stb & ~rd_stb;
  assign wr_go = wr_stb & ~rd_stb & ~commit_stb;

  assign lanes = (wr_go ? wr_data : '0) | (inject_all ? '1 : '0) | copy_bits;

  dwm_row_decode #(.ADDR_W(ADDR_W)) rd_dec_i (
    .addr(addr), .en(rd_go), .sel(rd_sel)
  );

  dwm_row_decode #(.ADDR_W(ADDR_W)) cm_dec_i (
    .addr(row_now), .en(commit_go), .sel(cm_sel)
  );

  dwm_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .cm_sel(cm_sel),
    .cm_bits(commit_bits), .sel_word(sel_word)
  );

  dwm_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cap_i (
    .clk(clk), .rst(rst), .wr_go(wr_go), .cm_go(cm_go), .addr(addr),
    .lanes(lanes), .lane_act(inject_all | copy_act), .open_now(open_now),
    .row_now(row_now), .commit_go(commit_go), .commit_bits(commit_bits),
    .pass_go(pass_go)
  );

  dwm_regen #(.DATA_W(DATA_W)) regen_i (
    .clk(clk), .rst(rst), .load(rd_go), .load_bits(sel_word), .cmd(cmd),
    .copy_act(copy_act), .copy_bits(copy_bits), .rel_go(rel_go),
    .rel_bits(rel_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      fwd_valid  <= 1'b0;
      fwd_data   <= '0;
      pass_valid <= 1'b0;
      pass_data  <= '0;
    end else begin
      rd_valid   <= rd_go;
      rd_data    <= rd_go ? sel_word : '0;
      fwd_valid  <= rel_go;
      fwd_data   <= rel_go ? rel_bits : '0;
      pass_valid <= pass_go;
      pass_data  <= (pass_go && open_now == 1'b0) ? lanes : '0;
    end
  end
endmodule

// File: rtl/dwm_chk.sv
module dwm_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_stb,
  input logic              inject_all,
  input logic [1:0]        regen_cmd,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              fwd_valid,
  input logic [DATA_W-1:0] fwd_data,
  input logic              pass_valid,
  input logic [DATA_W-1:0] pass_data
);
  // R12
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rd_valid);

  // R9
  rel_forward_chk: assert property (@(posedge clk) disable iff (rst)
    (regen_cmd == 2'd2) |=> fwd_valid);

  // R9
  rel_empties_chk: assert property (@(posedge clk) disable iff (rst)
    ((regen_cmd == 2'd2) && !rd_stb) ##1 (regen_cmd == 2'd2) |=> (fwd_data == '0));

  // R3
  rd_empties_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stb ##1 (rd_stb && addr == $past(addr)) |=> (rd_data == '0));

  // R6
  pass_source_chk: assert property (@(posedge clk) disable iff (rst)
    pass_valid |-> $past(inject_all || regen_cmd == 2'd1));

  // R7
  all_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (pass_valid && $past(inject_all)) |-> (pass_data == '1));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rd_valid && !fwd_valid && !pass_valid));
endmodule

bind dr_word_mem dwm_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .addr(addr), .rd_stb(rd_stb),
  .inject_all(inject_all), .regen_cmd(regen_cmd), .rd_valid(rd_valid),
  .rd_data(rd_data), .fwd_valid(fwd_valid), .fwd_data(fwd_data),
  .pass_valid(pass_valid), .pass_data(pass_data)
);

// File: tb/dr_word_mem_tb_top.sv
module dr_word_mem_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic       rd_stb = 1'b0, wr_stb = 1'b0, commit_stb = 1'b0, inject_all = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] regen_cmd = 2'd0;
  logic       rd_valid, fwd_valid, pass_valid;
  logic [7:0] rd_data, fwd_data, pass_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  dr_word_mem dut_i (
    .clk(clk), .rst(rst), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .commit_stb(commit_stb), .inject_all(inject_all),
    .regen_cmd(regen_cmd), .rd_valid(rd_valid), .rd_data(rd_data),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .pass_valid(pass_valid),
    .pass_data(pass_data)
  );

  typedef enum int {CH_RD, CH_FWD, CH_PASS} chan_e;
  typedef struct {
    chan_e      ch;
    logic [7:0] data;
    int         due;
    string      tag;
  } item_t;

  item_t      sb_q[$];
  int         n_checks = 0;
  int         n_errors = 0;
  int         cyc = 0;

  // bench model state
  logic [7:0] m_mem [16];
  logic       m_open = 1'b0;
  logic [3:0] m_row = '0;
  logic [7:0] m_cap = '0;
  logic [7:0] m_regen = '0;

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expect_item(input chan_e ch, input logic [7:0] d, input string tag);
    item_t it;
    it.ch = ch; it.data = d; it.due = cyc + 1; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // driver: one clock per call, model updated from the requirements
  task automatic step(input bit rd, input bit wr, input bit cm, input logic [3:0] a,
                      input logic [7:0] d, input bit all, input logic [1:0] cmd,
                      input string tag);
    bit rd_e, cm_e, wr_e, cp, rel, open_now;
    logic [7:0] lanes, old;
    logic [3:0] row;
    rd_e = rd;
    cm_e = cm && !rd;
    wr_e = wr && !rd && !cm;
    cp   = (cmd == 2'd1);
    rel  = (cmd == 2'd2);
    lanes = (wr_e ? d : 8'h00) | (all ? 8'hFF : 8'h00) | (cp ? m_regen : 8'h00);
    open_now = m_open || wr_e;
    row = wr_e ? a : m_row;
    if (rd_e) expect_item(CH_RD, m_mem[a], tag);
    if (rel) expect_item(CH_FWD, m_regen, tag);
    if (!open_now && (all || cp)) expect_item(CH_PASS, lanes, tag);
    old = m_mem[a];
    if (rd_e) m_mem[a] = 8'h00;
    if (cm_e && open_now) begin
      m_mem[row] = m_mem[row] | m_cap | lanes;
      m_open = 1'b0;
      m_cap = 8'h00;
    end else if (open_now) begin
      m_open = 1'b1;
      m_row = row;
      m_cap = m_cap | lanes;
    end
    if (rd_e) m_regen = old;
    else if (rel) m_regen = 8'h00;
    rd_stb = rd; wr_stb = wr; commit_stb = cm; addr = a; wr_data = d;
    inject_all = all; regen_cmd = cmd;
    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b0; commit_stb = 1'b0; inject_all = 1'b0;
    regen_cmd = 2'd0; wr_data = 8'h00;
  endtask

  task automatic rd_word(input logic [3:0] a, input string tag);
    step(1, 0, 0, a, 8'h00, 0, 2'd0, tag);
  endtask

  task automatic wr_word(input logic [3:0] a, input logic [7:0] d, input string tag);
    step(0, 1, 0, a, d, 0, 2'd0, tag);
  endtask

  task automatic commit(input string tag);
    step(0, 0, 1, 4'h0, 8'h00, 0, 2'd0, tag);
  endtask

  task automatic regen(input logic [1:0] cmd, input string tag);
    step(0, 0, 0, 4'h0, 8'h00, 0, cmd, tag);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop items due this cycle and compare, flag unexpected outputs
  always @(negedge clk) begin
    bit er, ef, ep;
    er = 0; ef = 0; ep = 0;
    if (!rst) begin
      while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
        item_t it;
        it = sb_q.pop_front();
        case (it.ch)
          CH_RD: begin
            er = 1;
            check(rd_valid === 1'b1 && rd_data === it.data, {it.tag, " rd_data"}, rd_data, it.data);
          end
          CH_FWD: begin
            ef = 1;
            check(fwd_valid === 1'b1 && fwd_data === it.data, {it.tag, " fwd_data"}, fwd_data, it.data);
          end
          default: begin
            ep = 1;
            check(pass_valid === 1'b1 && pass_data === it.data, {it.tag, " pass_data"}, pass_data, it.data);
          end
        endcase
      end
      if (!er && rd_valid !== 1'b0) check(0, "R12 unexpected rd_valid", rd_data, 8'h00);
      if (!ef && fwd_valid !== 1'b0) check(0, "R12 unexpected fwd_valid", fwd_data, 8'h00);
      if (!ep && pass_valid !== 1'b0) check(0, "R6 unexpected pass_valid", pass_data, 8'h00);
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYC);
    check(0, "watchdog expired", 8'h00, 8'h00);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: outputs quiet while reset is held
    check(rd_valid === 1'b0 && fwd_valid === 1'b0 && pass_valid === 1'b0,
          "R1 reset outputs", {5'b0, rd_valid, fwd_valid, pass_valid}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 16; i++) rd_word(4'(i), "R1 word empty after reset");

    // R4: capture, not stored until commit; R2: other rows untouched
    wr_word(4'd3, 8'hA5, "R4 open row");
    rd_word(4'd3, "R4 read before commit");
    commit("R4 commit");
    rd_word(4'd5, "R2 neighbour row");
    rd_word(4'd2, "R2 neighbour row");
    rd_word(4'd3, "R3 first read");
    rd_word(4'd3, "R3 second read empty");

    // R5: OR merge of two writes
    wr_word(4'd7, 8'h0F, "R5 first write");
    commit("R5 commit a");
    wr_word(4'd7, 8'h30, "R5 second write");
    commit("R5 commit b");
    rd_word(4'd7, "R5 merged value");

    // R8: regenerate after read; R9 release
    wr_word(4'd9, 8'hC3, "R8 write");
    commit("R8 commit");
    rd_word(4'd9, "R8 destructive read");
    wr_word(4'd9, 8'h00, "R8 reopen row");
    regen(2'd1, "R8 copy into row");
    commit("R8 commit copy");
    rd_word(4'd9, "R8 restored word");
    regen(2'd2, "R9 first release");
    regen(2'd2, "R9 second release empty");

    // R10: copy from an empty latch
    wr_word(4'd2, 8'h01, "R10 write");
    regen(2'd1, "R10 empty copy");
    commit("R10 commit");
    rd_word(4'd2, "R10 word unchanged by copy");
    regen(2'd2, "R10 drain latch");

    // R6: pass-through with no row open
    step(0, 0, 0, 4'h0, 8'h00, 1, 2'd0, "R6 inject_all pass");
    wr_word(4'd11, 8'h5A, "R6 setup");
    commit("R6 setup commit");
    rd_word(4'd11, "R6 load latch");
    regen(2'd1, "R6 copy passes through");
    regen(2'd3, "R8 code 3 neutral");
    regen(2'd2, "R9 release after code 3");

    // R7: all ones into open row
    wr_word(4'd12, 8'h00, "R7 open");
    step(0, 0, 0, 4'h0, 8'h00, 1, 2'd0, "R7 inject ones");
    commit("R7 commit");
    rd_word(4'd12, "R7 all ones stored");

    // R11: read beats write, commit beats write
    wr_word(4'd4, 8'h11, "R11 setup");
    commit("R11 setup commit");
    step(1, 1, 0, 4'd4, 8'h22, 0, 2'd0, "R11 read over write");
    commit("R11 no row open");
    rd_word(4'd4, "R11 write ignored");
    wr_word(4'd6, 8'h40, "R11 open row 6");
    step(0, 1, 1, 4'd6, 8'h02, 0, 2'd0, "R11 commit over write");
    step(0, 0, 0, 4'h0, 8'h00, 1, 2'd0, "R11 row closed");
    rd_word(4'd6, "R11 commit value");

    // R9: read and release in one cycle
    wr_word(4'd8, 8'h81, "R9 setup");
    commit("R9 setup commit");
    step(1, 0, 0, 4'd8, 8'h00, 0, 2'd2, "R9 read with release");
    regen(2'd2, "R9 latch holds new word");

    // R2: sweep every word against the model
    for (int i = 0; i < 16; i++) rd_word(4'(i), "R2 final sweep");
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R12 scoreboard drained", 8'(sb_q.size()), 8'h00);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule